// File: doc/BRIEF.md
# Pixel Depth Packer and Wide-Sample Byte Formatter

This block sits at the tail of a pixel pipeline and turns a stream of processed samples into a byte stream for an image buffer. A mode input selects one of two formats. The packed format reduces each 8-bit sample to 1, 2, 4 or 8 bits and places several reduced pixels into one byte. The wide format sends each 10-bit or 12-bit sample as two bytes, and the bit layout differs between the two widths.

Samples arrive on a valid/ready stream that carries an end-of-line flag. Bytes leave on a valid/ready stream. A sample is taken on any rising clock edge where `s_valid` and `s_ready` are both high. A byte is handed over on any rising edge where `m_valid` and `m_ready` are both high. While `m_valid` is high and `m_ready` is low, the output byte stays frozen and no new sample is accepted. In wide mode the block also holds off the input until the second byte of the current sample has moved into the output register. The configuration inputs must stay unchanged while a line is in flight.

Top module: `pix_pack_fmt`

## Requirements
- R1: After reset, `m_valid` is low and `s_ready` is high.
- R2: In packed mode, `cfg_depth` selects the pixel depth: 00 = 1 bit, 01 = 2 bits, 10 = 4 bits, 11 = 8 bits. Each pixel keeps the most significant bits of `s_data[7:0]`.
- R3: In packed mode, each full byte holds 8, 4, 2 or 1 pixels. The earliest pixel is in the most significant bits. No byte is emitted before it is full, unless the end of a line is reached.
- R4: A sample with `s_eol` high ends the line. A partly filled byte is then emitted with its unused low bits set to zero, and the next line starts with an empty byte.
- R5: In wide mode (`cfg_wide`=1) with `cfg_w12`=0, a sample is sent as two bytes in this order: {0000, `s_data[9:6]`}, then {`s_data[5:0]`, 00}.
- R6: In wide mode with `cfg_w12`=1, a sample is sent as two bytes in this order: {0000, `s_data[11:8]`}, then `s_data[7:0]`.
- R7: While `m_valid` is high and `m_ready` is low, `m_data` stays stable and `s_ready` is low. Every byte is delivered once and in order, with no loss and no duplicate.
- R8: A byte that a sample completes is valid in the cycle after the edge that accepted the sample. In wide mode, the second byte is valid in the cycle after the first byte is taken.
- R9: In packed mode, `s_data[11:8]` has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wide | input | 1 | 0 = packed format, 1 = wide two-byte format |
| cfg_w12 | input | 1 | Wide width select: 0 = 10-bit, 1 = 12-bit |
| cfg_depth | input | 2 | Packed pixel depth code |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample accepted when high together with s_valid |
| s_data | input | WIDE_W | Sample value |
| s_eol | input | 1 | Marks the last sample of a line |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Downstream accepts the byte |
| m_data | output | BYTE_W | Output byte |

## Verification
Every output byte comes from a single register. It therefore becomes visible one cycle after the accepting edge: for the byte that a sample completes, for the flushed byte at the end of a line, and for the first wide byte. The second wide byte arrives one cycle after the first byte is handed over. The bench drives inputs just after a rising edge and records transfers at the falling edge before the edge that completes them, so each byte is captured in the cycle it is due. The latency check samples at the first falling edge after the accepting edge. The stall checks sample during the cycles in which `m_ready` is held low.

// File: rtl/pk_pkg.sv
package pk_pkg;

  // Packed pixel depth codes; the code value is log2 of the bit count
  typedef enum logic [1:0] {
    DEPTH_1 = 2'b00,
    DEPTH_2 = 2'b01,
    DEPTH_4 = 2'b10,
    DEPTH_8 = 2'b11
  } depth_e;

endpackage

// File: rtl/pk_slice.sv
// Reduces a sample to the selected depth and places it in its slot of the byte
module pk_slice
  import pk_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CNT_W  = $clog2(BYTE_W)
) (
  input  depth_e              depth,
  input  logic [BYTE_W-1:0]   sample,
  input  logic [CNT_W-1:0]    slot,
  output logic [BYTE_W-1:0]   placed,
  output logic                last_slot
);
  localparam int N_DEPTH = $clog2(BYTE_W) + 1;

  logic [BYTE_W-1:0] cand      [N_DEPTH];
  logic              cand_last [N_DEPTH];

  for (genvar g = 0; g < N_DEPTH; g++) begin : g_depth
    localparam int BITS = 1 << g;
    localparam int PPB  = BYTE_W / BITS;
    logic [CNT_W-1:0] pos;
    assign pos          = slot & CNT_W'(PPB - 1);
    // earliest slot lands in the most significant bits
    assign cand[g]      = BYTE_W'(sample[BYTE_W-1 -: BITS]) << (BYTE_W - BITS * (int'(pos) + 1));
    assign cand_last[g] = (pos == CNT_W'(PPB - 1));
  end

  assign placed    = cand[depth];
  assign last_slot = cand_last[depth];
endmodule

// File: rtl/pk_wide_split.sv
// Splits a wide sample into a high and a low byte
module pk_wide_split #(
  parameter int WIDE_W = 12,
  parameter int BYTE_W = 8
) (
  input  logic [WIDE_W-1:0] sample,
  input  logic              w12,
  output logic [BYTE_W-1:0] hi_byte,
  output logic [BYTE_W-1:0] lo_byte
);
  localparam int HI_BITS  = WIDE_W - BYTE_W;
  localparam int NARROW_W = WIDE_W - 2;
  localparam int PAD      = WIDE_W - NARROW_W;

  logic [BYTE_W-1:0] hi12, lo12, hi10, lo10;

  // 12-bit: high nibble right-aligned, then the low eight bits
  assign hi12 = BYTE_W'(sample[WIDE_W-1 -: HI_BITS]);
  assign lo12 = sample[BYTE_W-1:0];
  // 10-bit: the whole value is shifted up by two
  assign hi10 = BYTE_W'(sample[NARROW_W-1 -: HI_BITS]);
  assign lo10 = {sample[NARROW_W-HI_BITS-1:0], {PAD{1'b0}}};

  assign hi_byte = w12 ? hi12 : hi10;
  assign lo_byte = w12 ? lo12 : lo10;
endmodule

// File: rtl/pk_out_stage.sv
// Output byte register with one pending slot for the second wide byte
module pk_out_stage #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              push_two,
  input  logic [BYTE_W-1:0] byte_a,
  input  logic [BYTE_W-1:0] byte_b,
  output logic              can_take,
  input  logic              m_ready,
  output logic              m_valid,
  output logic [BYTE_W-1:0] m_data
);
  logic              pend_v;
  logic [BYTE_W-1:0] pend_d;
  logic              out_free;

  assign out_free = !m_valid || m_ready;
  assign can_take = out_free && !pend_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      pend_v  <= 1'b0;
      pend_d  <= '0;
    end else if (push) begin
      m_valid <= 1'b1;
      m_data  <= byte_a;
      pend_v  <= push_two;
      pend_d  <= byte_b;
    end else if (out_free) begin
      if (pend_v) begin
        m_valid <= 1'b1;
        m_data  <= pend_d;
        pend_v  <= 1'b0;
      end else begin
        m_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pix_pack_fmt.sv
module pix_pack_fmt
  import pk_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int WIDE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wide,
  input  logic              cfg_w12,
  input  logic [1:0]        cfg_depth,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [WIDE_W-1:0] s_data,
  input  logic              s_eol,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [BYTE_W-1:0] m_data
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] acc;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] placed, merged, hi_b, lo_b;
  logic              last_slot, accept, emit, push, can_take;

  pk_slice #(.BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_slice (
    .depth    (depth_e'(cfg_depth)),
    .sample   (s_data[BYTE_W-1:0]),
    .slot     (cnt),
    .placed   (placed),
    .last_slot(last_slot)
  );

  pk_wide_split #(.WIDE_W(WIDE_W), .BYTE_W(BYTE_W)) u_split (
    .sample (s_data),
    .w12    (cfg_w12),
    .hi_byte(hi_b),
    .lo_byte(lo_b)
  );

  assign s_ready = can_take;
  assign accept  = s_valid && can_take;
  assign merged  = acc | placed;
  assign emit    = accept && !cfg_wide && (last_slot || s_eol);
  assign push    = emit || (accept && cfg_wide);

  pk_out_stage #(.BYTE_W(BYTE_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (push),
    .push_two(cfg_wide),
    .byte_a  (cfg_wide ? hi_b : merged),
    .byte_b  (lo_b),
    .can_take(can_take),
    .m_ready (m_ready),
    .m_valid (m_valid),
    .m_data  (m_data)
  );

  // partial-byte accumulator for packed mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      cnt <= '0;
    end else if (accept && !cfg_wide) begin
      if (emit) begin
        acc <= '0;
        cnt <= '0;
      end else begin
        acc <= merged;
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pk_chk.sv
module pk_chk #(
  parameter int BYTE_W = 8,
  parameter int WIDE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wide,
  input logic              cfg_w12,
  input logic [1:0]        cfg_depth,
  input logic              s_valid,
  input logic              s_ready,
  input logic [WIDE_W-1:0] s_data,
  input logic              s_eol,
  input logic              m_valid,
  input logic              m_ready,
  input logic [BYTE_W-1:0] m_data
);
  logic acc_ok;
  assign acc_ok = s_valid && s_ready;

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !m_valid);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  // R7
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready);

  // R4
  eol_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && !cfg_wide && s_eol) |=> m_valid);

  // R2
  full_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && !cfg_wide && cfg_depth == 2'b11) |=> (m_valid && m_data == $past(s_data[BYTE_W-1:0])));

  // R6
  wide12_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && cfg_wide && cfg_w12) |=> (m_valid && m_data == BYTE_W'($past(s_data[WIDE_W-1:BYTE_W]))));

  // R5
  wide10_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && cfg_wide && !cfg_w12) |=> (m_valid && m_data == BYTE_W'($past(s_data[WIDE_W-3:BYTE_W-2]))));

  // R8
  wide_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && cfg_wide) |=> !s_ready);
endmodule

bind pix_pack_fmt pk_chk #(.BYTE_W(BYTE_W), .WIDE_W(WIDE_W)) u_chk (.*);

// File: tb/tb_pix_pack_fmt.sv
module tb_pix_pack_fmt;
  localparam int CLK_P = 10;
  localparam int NV    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wide = 1'b0, cfg_w12 = 1'b0;
  logic [1:0] cfg_depth = 2'b00;
  logic s_valid = 1'b0, s_eol = 1'b0, m_ready = 1'b1;
  logic [11:0] s_data = '0;
  logic s_ready, m_valid;
  logic [7:0] m_data;

  int checks = 0, fails = 0;
  int ngot = 0;
  logic [7:0] got [256];

  always #(CLK_P/2) clk = ~clk;

  pix_pack_fmt dut (.*);

  // config {wide, w12, depth}
  localparam logic [3:0] T_CFG [NV] = '{4'b0000, 4'b0000, 4'b0001, 4'b0001, 4'b0010,
                                         4'b0011, 4'b1000, 4'b1100, 4'b0010, 4'b0000};
  localparam int T_N [NV] = '{8, 3, 4, 5, 3, 2, 1, 1, 2, 1};
  localparam logic [11:0] T_SMP [NV][8] = '{
    '{12'hF9A, 12'h040, 12'h0C1, 12'h080, 12'h07F, 12'h000, 12'h0FF, 12'h012},
    '{12'h080, 12'h080, 12'h000, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0},
    '{12'h0C0, 12'h040, 12'h080, 12'h03F, 12'h0, 12'h0, 12'h0, 12'h0},
    '{12'h040, 12'h040, 12'h040, 12'h040, 12'h0C5, 12'h0, 12'h0, 12'h0},
    '{12'h0A7, 12'h03C, 12'h0E1, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0},
    '{12'h5C3, 12'h001, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0},
    '{12'h3A5, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0},
    '{12'hA5C, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0},
    '{12'h01F, 12'h0F0, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0},
    '{12'h0FF, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0}};
  localparam int T_NE [NV] = '{1, 1, 1, 2, 2, 2, 2, 2, 1, 1};
  localparam logic [15:0] T_EXP [NV] = '{16'hB200, 16'hC000, 16'hD800, 16'h55C0, 16'hA3E0,
                                          16'hC301, 16'h0E94, 16'h0A5C, 16'h1F00, 16'h8000};

  // transfer completes at the next rising edge
  always @(negedge clk) if (rst_n && m_valid && m_ready) begin
    got[ngot[7:0]] = m_data;
    ngot = ngot + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_px(input logic [11:0] d, input logic eol);
    @(negedge clk);
    s_valid = 1'b1; s_data = d; s_eol = eol;
    while (!s_ready) @(negedge clk);
    @(posedge clk); #1;
    s_valid = 1'b0; s_eol = 1'b0;
  endtask

  task automatic set_cfg(input logic [3:0] c);
    {cfg_wide, cfg_w12, cfg_depth} = c;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 m_valid", int'(m_valid), 0);
    chk("R1 s_ready", int'(s_ready), 1);

    // table walk: lines run back to back, each ending with eol (R2 R3 R4 R5 R6 R9)
    for (int e = 0; e < NV; e++) begin
      set_cfg(T_CFG[e]);
      base = ngot;
      for (int i = 0; i < T_N[e]; i++) push_px(T_SMP[e][i], i == T_N[e] - 1);
      repeat (4) @(negedge clk);
      chk($sformatf("R2 R3 R4 R5 R6 count e%0d", e), ngot - base, T_NE[e]);
      chk($sformatf("R3 R4 R5 R6 R9 byte0 e%0d", e), int'(got[base[7:0]]), int'(T_EXP[e][15:8]));
      if (T_NE[e] == 2)
        chk($sformatf("R4 R5 R6 byte1 e%0d", e), int'(got[base[7:0]+8'd1]), int'(T_EXP[e][7:0]));
    end

    // R3: no output before the byte is full
    set_cfg(4'b0000);
    base = ngot;
    push_px(12'h080, 1'b0); push_px(12'h000, 1'b0); push_px(12'h080, 1'b0);
    repeat (2) @(negedge clk);
    chk("R3 no early byte", int'(m_valid), 0);
    push_px(12'h080, 1'b0); push_px(12'h080, 1'b0); push_px(12'h000, 1'b0);
    push_px(12'h000, 1'b0); push_px(12'h080, 1'b0);
    repeat (3) @(negedge clk);
    chk("R3 one byte", ngot - base, 1);
    chk("R3 byte", int'(got[base[7:0]]), 8'hB9);

    // R8: latency of a completed byte
    set_cfg(4'b0011);
    push_px(12'h0A5, 1'b1);
    @(negedge clk);
    chk("R8 valid next cycle", int'(m_valid), 1);
    chk("R8 data next cycle", int'(m_data), 8'hA5);
    repeat (2) @(negedge clk);

    // R7: stall in wide mode holds byte and input
    set_cfg(4'b1100);
    m_ready = 1'b0;
    base = ngot;
    push_px(12'h3C7, 1'b1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R7 held valid", int'(m_valid), 1);
      chk("R7 held data", int'(m_data), 8'h03);
      chk("R7 input blocked", int'(s_ready), 0);
    end
    @(posedge clk); #1 m_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 wide count", ngot - base, 2);
    chk("R7 wide first", int'(got[base[7:0]]), 8'h03);
    chk("R7 wide second", int'(got[base[7:0]+8'd1]), 8'hC7);

    // R7: stall in packed mode, second pixel waits
    set_cfg(4'b0011);
    m_ready = 1'b0;
    base = ngot;
    fork
      begin push_px(12'h011, 1'b0); push_px(12'h022, 1'b1); end
      begin
        repeat (4) @(negedge clk);
        chk("R7 packed blocked", int'(s_ready), 0);
        chk("R7 packed held", int'(m_data), 8'h11);
        @(posedge clk); #1 m_ready = 1'b1;
      end
    join
    repeat (4) @(negedge clk);
    chk("R7 packed count", ngot - base, 2);
    chk("R7 packed order0", int'(got[base[7:0]]), 8'h11);
    chk("R7 packed order1", int'(got[base[7:0]+8'd1]), 8'h22);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule